// File: doc/BRIEF.md
# Ethernet Transmit Frame Finisher

This block sits on the transmit side of an Ethernet port, between the logic that produces frames and the line encoder. Frames arrive one byte per beat on a valid/ready stream that marks the first and last byte of each frame and carries a per-frame skip flag. For a normal frame the block can overwrite the source MAC address with a configured station address, stretch a short frame to the Ethernet minimum with zero bytes, and append a CRC-32 frame check sequence. When the skip flag is set, the frame passes through byte for byte. Its last four bytes then serve as the FCS, so a checksum that was computed upstream, or deliberately altered, reaches the line unchanged.

Back-pressure: a byte moves on either stream only in a cycle where valid and ready are both high. While it carries frame body bytes, the block is a combinational pass-through. The output valid follows the input valid, and the input ready follows the output ready, so no byte is held inside the block. While it appends pad or FCS bytes, the block drives the output on its own and holds the input ready low. A source that raises valid must keep its byte and markers steady until that byte is accepted. The block does the same for the bytes it appends.

The skip flag and the address-insertion enable count only on the first beat of a frame. The block keeps them until that frame ends. The first beat must carry the start marker.

Top module: `eth_tx_finisher`

## Requirements
- R1: Each body byte accepted on the input appears on the output in the same cycle and in order. After any cycle in which the output shows valid without ready, the next cycle shows the same byte with valid still high.
- R2: The skip flag and the insertion enable are taken from the first beat of a frame. Changing either one on a later beat of the same frame changes no output byte.
- R3: When skip is 0 and insertion is enabled, frame bytes 6 to 11 (counted from 0 at the first destination address byte) are replaced by the 48-bit station address, sent most significant byte first.
- R4: When skip is 1, bytes 6 to 11 leave the block exactly as they entered, whatever the insertion enable.
- R5: When skip is 0 and a frame has fewer than 60 data bytes, zero bytes are added after its last data byte until 60 bytes have been sent, so the finished frame is 64 bytes long.
- R6: When skip is 1, the output frame has the same length as the input frame, and the end marker comes out with the last input byte.
- R7: When skip is 0, four FCS bytes follow the data and pad. They hold the bitwise inverse of a reflected CRC-32 with polynomial 0x04C11DB7 and seed all ones, computed over every byte sent before them, and are sent least significant byte first. The end marker is on the fourth of these bytes.
- R8: When skip is 1, no checksum is added, and the last four input bytes are sent unchanged as the frame's FCS.
- R9: While pad or FCS bytes are being sent, the input ready is low. The start marker appears only on a frame's first output byte.
- R10: Frames sent back to back with different skip settings are each finished according to their own flag.
- R11: After reset, with no input offered, the output valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sa_insert_en | input | 1 | Replace the source address of non-skip frames |
| station_addr | input | 48 | Address written into bytes 6..11, MSB first |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts the input byte |
| in_data | input | 8 | Input frame byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_skip | input | 1 | Pass this frame through untouched (read on first beat) |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts the output byte |
| out_data | output | 8 | Output frame byte |
| out_sof | output | 1 | First byte of an output frame |
| out_eof | output | 1 | Last byte of an output frame |

## Verification
The assertions check on every cycle that the input stays stalled while bytes are being appended, that appended bytes stay steady under back-pressure, that pad bytes are zero, that every frame ending in generated FCS bytes is at least 64 bytes long, and that the sequencer returns to idle after each end marker. Only the bench scenarios can show that the address bytes land on the correct positions in the correct order, that the checksum value is right, that a mid-frame flag change has no effect, and that skip frames come out bit-exact. For these, each output byte is compared with a reference frame built from the requirements, with the sink applying irregular back-pressure.

// File: rtl/eth_fin_pkg.sv
package eth_fin_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_BODY = 2'd1,
    PH_PAD  = 2'd2,
    PH_FCS  = 2'd3
  } phase_t;

  typedef enum logic [1:0] {
    SRC_IN   = 2'd0,
    SRC_ZERO = 2'd1,
    SRC_FCS  = 2'd2
  } src_t;

  localparam int          FCS_BYTES    = 4;
  localparam logic [31:0] CRC_SEED     = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY_REV = 32'hEDB8_8320;  // 0x04C11DB7 reflected

  // One byte through the reflected CRC-32 register, LSB first.
  function automatic logic [31:0] crc_step(input logic [31:0] cur, input logic [7:0] b);
    logic [31:0] r;
    r = cur ^ {24'd0, b};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REV) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/eth_fin_crc.sv
module eth_fin_crc
  import eth_fin_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        advance,
  input  logic [7:0]  din,
  output logic [31:0] crc_q
);

  logic [31:0] base;

  // The first byte of a frame folds into a fresh seed, so no separate clear cycle is needed.
  assign base = start ? CRC_SEED : crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q <= CRC_SEED;
    end else if (advance) begin
      crc_q <= crc_step(base, din);
    end
  end

endmodule

// File: rtl/eth_fin_sa_ovr.sv
module eth_fin_sa_ovr #(
  parameter int SA_OFFSET  = 6,
  parameter int ADDR_BYTES = 6,
  parameter int CNT_W      = 6
) (
  input  logic [CNT_W-1:0]        idx,
  input  logic                    active,
  input  logic [8*ADDR_BYTES-1:0] addr,
  input  logic [7:0]              din,
  output logic [7:0]              dout
);

  logic [ADDR_BYTES-1:0] hit;
  logic [7:0]            lane [ADDR_BYTES];

  // One comparator per address byte; byte k of the field takes the k-th most significant octet.
  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_lane
    assign hit[k]  = (idx == CNT_W'(SA_OFFSET + k));
    assign lane[k] = addr[8*(ADDR_BYTES-1-k) +: 8];
  end

  always_comb begin
    dout = din;
    if (active) begin
      for (int k = 0; k < ADDR_BYTES; k++) begin
        if (hit[k]) dout = lane[k];
      end
    end
  end

endmodule

// File: rtl/eth_fin_seq.sv
module eth_fin_seq
  import eth_fin_pkg::*;
#(
  parameter int MIN_DATA = 60,
  parameter int CNT_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_skip,
  input  logic             sa_en,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             out_valid,
  output logic             out_sof,
  output logic             out_eof,
  output phase_t           phase,
  output logic [CNT_W-1:0] idx_cur,
  output logic             sa_active,
  output src_t             src,
  output logic [1:0]       fcs_sel,
  output logic             crc_start,
  output logic             crc_adv
);

  localparam int FW = $clog2(FCS_BYTES);

  phase_t            phase_q;
  logic [CNT_W-1:0]  idx_q;
  logic [FW-1:0]     fcs_q;
  logic              skip_q;
  logic              en_q;

  logic              first, body, skip_cur, en_cur, last_fcs, out_fire;
  logic [CNT_W:0]    idx_inc;
  logic [CNT_W-1:0]  idx_next;
  logic              short_frame;

  always_comb begin
    first    = (phase_q == PH_IDLE);
    body     = first || (phase_q == PH_BODY);
    skip_cur = first ? in_skip : skip_q;
    en_cur   = first ? sa_en   : en_q;
    idx_cur  = first ? '0      : idx_q;
    idx_inc  = {1'b0, idx_cur} + 1'b1;
    idx_next = (idx_inc >= (CNT_W+1)'(MIN_DATA)) ? CNT_W'(MIN_DATA) : idx_inc[CNT_W-1:0];
    short_frame = (idx_next < CNT_W'(MIN_DATA));
    last_fcs = (fcs_q == FW'(FCS_BYTES - 1));

    in_ready  = body && out_ready;
    out_valid = body ? in_valid : 1'b1;
    out_sof   = body && in_sof;
    out_eof   = body ? (in_eof && skip_cur) : ((phase_q == PH_FCS) && last_fcs);
    out_fire  = out_valid && out_ready;

    case (phase_q)
      PH_PAD:  src = SRC_ZERO;
      PH_FCS:  src = SRC_FCS;
      default: src = SRC_IN;
    endcase

    sa_active = body && en_cur && !skip_cur;
    crc_start = first;
    crc_adv   = out_fire && !skip_cur && (phase_q != PH_FCS);
    phase     = phase_q;
    fcs_sel   = 2'(fcs_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      fcs_q   <= '0;
      skip_q  <= 1'b0;
      en_q    <= 1'b0;
    end else if (out_fire) begin
      case (phase_q)
        PH_IDLE, PH_BODY: begin
          if (first) begin
            skip_q <= in_skip;
            en_q   <= sa_en;
          end
          idx_q <= idx_next;
          if (!in_eof)         phase_q <= PH_BODY;
          else if (skip_cur)   phase_q <= PH_IDLE;
          else if (short_frame) phase_q <= PH_PAD;
          else                 phase_q <= PH_FCS;
        end
        PH_PAD: begin
          idx_q <= idx_next;
          if (!short_frame) phase_q <= PH_FCS;
        end
        default: begin
          if (last_fcs) begin
            fcs_q   <= '0;
            phase_q <= PH_IDLE;
          end else begin
            fcs_q <= fcs_q + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/eth_tx_finisher.sv
module eth_tx_finisher
  import eth_fin_pkg::*;
#(
  parameter int MIN_FRAME  = 64,
  parameter int SA_OFFSET  = 6,
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sa_insert_en,
  input  logic [8*ADDR_BYTES-1:0] station_addr,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [7:0]              in_data,
  input  logic                    in_sof,
  input  logic                    in_eof,
  input  logic                    in_skip,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [7:0]              out_data,
  output logic                    out_sof,
  output logic                    out_eof
);

  localparam int MIN_DATA = MIN_FRAME - FCS_BYTES;
  localparam int CNT_W    = $clog2(MIN_DATA + 1);

  phase_t           phase_w;
  src_t             src_w;
  logic [CNT_W-1:0] idx_w;
  logic             sa_active_w, crc_start_w, crc_adv_w;
  logic [1:0]       fcs_sel_w;
  logic [7:0]       body_byte;
  logic [31:0]      crc_w, fcs_w;

  eth_fin_seq #(
    .MIN_DATA (MIN_DATA),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_eof    (in_eof),
    .in_skip   (in_skip),
    .sa_en     (sa_insert_en),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_eof   (out_eof),
    .phase     (phase_w),
    .idx_cur   (idx_w),
    .sa_active (sa_active_w),
    .src       (src_w),
    .fcs_sel   (fcs_sel_w),
    .crc_start (crc_start_w),
    .crc_adv   (crc_adv_w)
  );

  eth_fin_sa_ovr #(
    .SA_OFFSET  (SA_OFFSET),
    .ADDR_BYTES (ADDR_BYTES),
    .CNT_W      (CNT_W)
  ) u_sa (
    .idx    (idx_w),
    .active (sa_active_w),
    .addr   (station_addr),
    .din    (in_data),
    .dout   (body_byte)
  );

  eth_fin_crc u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (crc_start_w),
    .advance (crc_adv_w),
    .din     (out_data),
    .crc_q   (crc_w)
  );

  assign fcs_w = ~crc_w;

  always_comb begin
    case (src_w)
      SRC_ZERO: out_data = 8'h00;
      SRC_FCS:  out_data = fcs_w[8*fcs_sel_w +: 8];
      default:  out_data = body_byte;
    endcase
  end

endmodule

// File: rtl/eth_fin_chk.sv
module eth_fin_chk
  import eth_fin_pkg::*;
#(
  parameter int MIN_FRAME = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_eof,
  input phase_t     phase
);

  logic [6:0] beats;
  logic       appending;

  assign appending = (phase == PH_PAD) || (phase == PH_FCS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beats <= '0;
    end else if (out_valid && out_ready) begin
      if (out_eof)             beats <= '0;
      else if (beats != 7'h7F) beats <= beats + 1'b1;
    end
  end

  AST_APPEND_STALLS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    appending |-> !in_ready);  // R9

  AST_APPEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (appending && out_valid && !out_ready) |=> (out_valid && $stable(out_data)));  // R1

  AST_PAD_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PAD && out_valid) |-> (out_data == 8'h00));  // R5

  AST_MIN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_eof && phase == PH_FCS) |-> (beats >= 7'(MIN_FRAME - 1)));  // R7

  AST_IDLE_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_eof) |=> (phase == PH_IDLE));  // R6

endmodule

bind eth_tx_finisher eth_fin_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_eof   (out_eof),
  .phase     (phase_w)
);

// File: tb/eth_tx_finisher_test.sv
module eth_tx_finisher_test;

  typedef struct {
    logic [7:0] data;
    logic       sof;
    logic       eof;
    logic       app;
    string      tag;
  } exp_t;

  localparam logic [47:0] SA = 48'h02A1_B2C3_D4E5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sa_insert_en = 1'b0;
  logic [47:0] station_addr = SA;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_sof = 1'b0, in_eof = 1'b0, in_skip = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        out_sof, out_eof;

  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;
  bit   bp_on  = 1'b0;
  exp_t exp_q[$];
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  eth_tx_finisher uut (
    .clk(clk), .rst_n(rst_n), .sa_insert_en(sa_insert_en), .station_addr(station_addr),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sof(in_sof),
    .in_eof(in_eof), .in_skip(in_skip), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof)
  );

  function automatic logic [31:0] ref_crc(input logic [7:0] b[$]);
    logic [31:0] c = 32'hFFFF_FFFF;
    foreach (b[i]) begin
      c = c ^ {24'd0, b[i]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic push(input logic [7:0] d, input bit s, input bit e, input bit a, input string t);
    exp_t x;
    x.data = d; x.sof = s; x.eof = e; x.app = a; x.tag = t;
    exp_q.push_back(x);
  endtask

  // Builds the expected frame from the requirements, then drives the input bytes.
  task automatic send_frame(input int len, input bit skip, input bit en, input bit flip,
                            input int seed, input string base);
    logic [7:0] src[$];
    logic [7:0] sent[$];
    logic [31:0] fcs;
    for (int i = 0; i < len; i++) src.push_back(8'((seed * 7 + i * 13 + 5) & 255));
    if (skip) begin
      for (int i = 0; i < len; i++) begin
        string k;
        k = (i >= len - 4) ? "R8" : ((i >= 6 && i <= 11) ? "R4" : "R6");
        push(src[i], i == 0, i == len - 1, 1'b0, {base, "/", k});
      end
    end else begin
      for (int i = 0; i < len; i++) begin
        logic [7:0] d;
        d = src[i];
        if (en && i >= 6 && i <= 11) d = SA[8*(11-i) +: 8];
        sent.push_back(d);
        push(d, i == 0, 1'b0, 1'b0, {base, (i >= 6 && i <= 11) ? "/R3" : "/R1"});
      end
      while (sent.size() < 60) begin
        sent.push_back(8'h00);
        push(8'h00, 1'b0, 1'b0, 1'b1, {base, "/R5"});
      end
      fcs = ref_crc(sent);
      for (int i = 0; i < 4; i++) push(fcs[8*i +: 8], 1'b0, i == 3, 1'b1, {base, "/R7"});
    end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = src[i];
      in_sof   = (i == 0);
      in_eof   = (i == len - 1);
      in_skip      = (flip && i > 0) ? ~skip : skip;
      sa_insert_en = (flip && i > 0) ? ~en : en;
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
    end
  endtask

  task automatic idle_until_drained();
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    while (exp_q.size() != 0 && !done) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = bp_on ? (lfsr[1:0] != 2'b00) : 1'b1;
  end

  // Monitor: compares every output handshake against the scoreboard head.
  logic       prev_stall = 1'b0;
  logic [7:0] prev_data  = '0;
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (prev_stall) begin
        checks++;
        if (!out_valid || out_data != prev_data) begin
          fails++;
          $display("FAIL R1 hold under back-pressure: valid=%0b data=%02h expected valid=1 data=%02h",
                   out_valid, out_data, prev_data);
        end
      end
      if (exp_q.size() != 0 && exp_q[0].app && in_valid) begin
        checks++;
        if (in_ready) begin
          fails++;
          $display("FAIL R9 in_ready during append: actual=1 expected=0");
        end
      end
      if (out_valid && out_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R6 unexpected output byte: actual=%02h expected=none", out_data);
        end else begin
          exp_t x;
          x = exp_q.pop_front();
          if (out_data !== x.data || out_sof !== x.sof || out_eof !== x.eof) begin
            fails++;
            $display("FAIL %s: actual data=%02h sof=%0b eof=%0b expected data=%02h sof=%0b eof=%0b",
                     x.tag, out_data, out_sof, out_eof, x.data, x.sof, x.eof);
          end
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R11 reset: out_valid=%0b expected=0", out_valid);
    end
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R11 after reset: out_valid=%0b expected=0", out_valid);
    end

    send_frame(14, 1'b0, 1'b1, 1'b0, 1, "R5");   // short frame, address inserted, padded
    send_frame(70, 1'b0, 1'b0, 1'b0, 2, "R7");   // long frame, no insertion, no pad
    send_frame(20, 1'b1, 1'b1, 1'b0, 3, "R10");  // skip frame right after a finished one
    send_frame(16, 1'b0, 1'b1, 1'b0, 4, "R10");  // and back to a finished one
    idle_until_drained();

    bp_on = 1'b1;
    send_frame(18, 1'b0, 1'b1, 1'b1, 5, "R2");   // flags flip mid-frame
    send_frame(12, 1'b1, 1'b0, 1'b1, 6, "R2");
    send_frame(60, 1'b0, 1'b1, 1'b0, 7, "R5");   // exactly minimum data: no pad
    send_frame(59, 1'b0, 1'b0, 1'b0, 8, "R5");   // one pad byte
    send_frame(1,  1'b0, 1'b1, 1'b0, 9, "R5");   // single-byte frame
    send_frame(5,  1'b1, 1'b1, 1'b0, 10, "R8");  // runt passed through
    send_frame(64, 1'b0, 1'b1, 1'b0, 11, "R3");
    idle_until_drained();

    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R6 missing output bytes: actual=%0d left expected=0", exp_q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule